// File: doc/BRIEF.md
# Cascadable Serial Result Readout

This block is the slave-side serial readout stage of a 16-bit data converter. A conversion-done strobe loads the parallel result into a shift register. An external host then clocks the result out, most significant bit first, on its own serial clock. The block only responds to that clock while the external-clock mode input is high and both active-low select inputs (chip select and read enable) are low. The serial clock and the selects are resynchronised into the much faster system clock, and their edges are found there. The serial clock may run continuously or in bursts, and in bursts it may rest high or low.

A cascade input allows several converters to be chained on one data line. The level on the cascade input is captured on each rising serial-clock edge. The output moves to the next bit on the falling edge. Once the local sixteen bits have left, the output carries the captured upstream bits in order, with no idle cycle in between. A busy flag rises on the conversion-start strobe. In read-after-convert operation it stays high until the last local bit has been shifted out.

Top module: `cascade_result_shifter`

## Requirements
- R1: A pulse on `conv_done` loads `conv_data` so that `ser_out` shows bit 15 before any serial clock. `ser_oe` is high exactly when `mode_ext` is 1 and the synchronised `cs_n` and `rd_n` are both 0.
- R2: While enabled, each rising `sclk` edge is followed by a falling edge that advances `ser_out` to the next lower bit. A host sampling `ser_out` at each rising edge reads the loaded word bit 15 first, down to bit 0.
- R3: `chain_in` is captured at each enabled rising edge. The capture from the k-th rising edge appears on `ser_out` after the (k+15)-th falling edge, so upstream bits follow bit 0 with no gap.
- R4: `busy` rises in the clock after `conv_start` and stays high through `conv_done`. It falls only when the sixteenth shift after a load takes place.
- R5: While `cs_n` is high, `sclk` activity neither shifts nor captures. The bit position is kept, and reading resumes at the next bit once `cs_n` returns low.
- R6: While `rd_n` is high or `mode_ext` is 0, `sclk` activity has no effect on `ser_out`.
- R7: With a serial clock that idles high, a falling edge that comes before any rising edge since the load does not shift. All sixteen bits are read in order.
- R8: A load in the middle of a readout discards the old word and restarts the bit count, so sixteen further shifts are needed before `busy` falls.
- R9: After reset, `ser_out`, `ser_oe` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 1 selects readout on the external serial clock |
| sclk | input | 1 | External serial clock, asynchronous |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| chain_in | input | 1 | Cascade data from the upstream device |
| conv_start | input | 1 | One-cycle strobe: conversion begins |
| conv_done | input | 1 | One-cycle strobe: result valid on conv_data |
| conv_data | input | 16 | Parallel conversion result |
| ser_out | output | 1 | Serial data output |
| ser_oe | output | 1 | Output drive enable for ser_out |
| busy | output | 1 | Conversion and readout in progress |

## Verification
A wrong bit counter shows at `busy`: the flag falls one or more serial cycles early or late, within the same readout. A lost or extra pending-edge state shifts the whole word by one position, so the first sampled bit already differs from bit 15. A capture register that misses an edge corrupts the seventeenth and later bits of a cascaded readout. A select gating fault moves `ser_out` during pulses that should be ignored, and the bit read after the pause then differs from the one expected.

// File: rtl/crs_pkg.sv
package crs_pkg;
   // Asynchronous pins that share one synchroniser, so their samples stay aligned
   typedef struct packed {
      logic chain;
      logic rd_n;
      logic cs_n;
      logic sclk;
   } crs_pins_t;

   localparam int unsigned PINS_W = $bits(crs_pins_t);
endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/crs_edge.sv
module crs_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   output logic rise,
   output logic fall
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= s;
   end

   assign rise = s & ~prev;
   assign fall = ~s & prev;
endmodule

// File: rtl/crs_shift.sv
module crs_shift #(
   parameter int unsigned W        = 16,
   parameter bit          CHAIN_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   input  logic         rise,
   input  logic         fall,
   input  logic         chain_bit,
   output logic         sout,
   output logic         last_shift
);
   localparam int unsigned CNT_W = $clog2(W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

   logic [W-1:0]     sreg;
   logic [CNT_W-1:0] cnt;
   logic             cap;
   logic             pend;   // a rising edge was seen since the last shift
   logic             fill;
   logic             do_cap;
   logic             do_shift;

   generate
      if (CHAIN_EN) begin : g_chain
         assign fill = cap;
      end else begin : g_nochain
         assign fill = 1'b0;
      end
   endgenerate

   assign do_cap   = en & rise & ~load;
   assign do_shift = en & fall & pend & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         cnt  <= '0;
         cap  <= 1'b0;
         pend <= 1'b0;
      end else if (load) begin
         sreg <= load_val;
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (do_cap) begin
            cap  <= chain_bit;
            pend <= 1'b1;
         end
         if (do_shift) begin
            sreg <= {sreg[W-2:0], fill};
            pend <= 1'b0;
            if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
         end
      end
   end

   assign sout       = sreg[W-1];
   assign last_shift = do_shift & (cnt == CNT_LAST);
endmodule

// File: rtl/crs_busy.sv
module crs_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy <= 1'b0;
      else if (start) busy <= 1'b1;
      else if (done)  busy <= 1'b0;
   end
endmodule

// File: rtl/cascade_result_shifter.sv
module cascade_result_shifter #(
   parameter int unsigned RES_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CHAIN_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_ext,
   input  logic             sclk,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             chain_in,
   input  logic             conv_start,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_data,
   output logic             ser_out,
   output logic             ser_oe,
   output logic             busy
);
   import crs_pkg::*;

   localparam crs_pins_t PINS_RST = '{chain: 1'b0, rd_n: 1'b1, cs_n: 1'b1, sclk: 1'b0};

   generate
      if (RES_W < 2) begin : g_bad_width
         $error("cascade_result_shifter: RES_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cascade_result_shifter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   crs_pins_t pins_raw;
   crs_pins_t pins_s;
   logic      sclk_rise;
   logic      sclk_fall;
   logic      rd_active;
   logic      last_shift;

   assign pins_raw = '{chain: chain_in, rd_n: rd_n, cs_n: cs_n, sclk: sclk};

   crs_sync #(
      .STAGES (SYNC_STAGES),
      .W      (PINS_W),
      .RST_VAL(PINS_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_s)
   );

   crs_edge #(
      .RST_VAL(1'b0)
   ) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .s    (pins_s.sclk),
      .rise (sclk_rise),
      .fall (sclk_fall)
   );

   assign rd_active = mode_ext & ~pins_s.cs_n & ~pins_s.rd_n;

   crs_shift #(
      .W       (RES_W),
      .CHAIN_EN(CHAIN_EN)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (conv_done),
      .load_val  (conv_data),
      .en        (rd_active),
      .rise      (sclk_rise),
      .fall      (sclk_fall),
      .chain_bit (pins_s.chain),
      .sout      (ser_out),
      .last_shift(last_shift)
   );

   crs_busy u_busy (
      .clk  (clk),
      .rst_n(rst_n),
      .start(conv_start),
      .done (last_shift),
      .busy (busy)
   );

   assign ser_oe = rd_active;
endmodule

// File: rtl/crs_checker.sv
module crs_checker (
   input logic clk,
   input logic rst_n,
   input logic conv_start,
   input logic conv_done,
   input logic conv_msb,
   input logic rd_active,
   input logic ser_out,
   input logic busy
);
   // R4: busy can only be raised by a conversion start
   assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(conv_start));

   // R4: busy only drops on a shift, which needs an active read
   assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(rd_active));

   // R1: a load presents the result MSB on the next clock
   assert_load_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> (ser_out == $past(conv_msb)));

   // R5 / R6: without an active read and without a load the output holds
   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_active && !conv_done) |=> $stable(ser_out));
endmodule

bind cascade_result_shifter crs_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .conv_start(conv_start),
   .conv_done (conv_done),
   .conv_msb  (conv_data[RES_W-1]),
   .rd_active (rd_active),
   .ser_out   (ser_out),
   .busy      (busy)
);

// File: tb/sim_cascade_result_shifter.sv
module sim_cascade_result_shifter;
   localparam int CLK_P = 10;
   localparam int HALF  = 4;   // serial half period in system clocks

   typedef struct {
      logic  val;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_ext = 1'b1;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        chain_in = 1'b0;
   logic        conv_start = 1'b0;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = '0;
   logic        ser_out;
   logic        ser_oe;
   logic        busy;

   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   exp_t exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   cascade_result_shifter u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_ext  (mode_ext),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .rd_n      (rd_n),
      .chain_in  (chain_in),
      .conv_start(conv_start),
      .conv_done (conv_done),
      .conv_data (conv_data),
      .ser_out   (ser_out),
      .ser_oe    (ser_oe),
      .busy      (busy)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: the host samples at each rising serial edge while selected
   always @(posedge sclk) begin
      if (!cs_n && !rd_n && mode_ext) begin
         n_run++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R2: actual %0b expected none (queue empty)", ser_out);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (ser_out !== e.val) begin
               n_fail++;
               $display("FAIL %s: actual %0b expected %0b", e.tag, ser_out, e.val);
            end
         end
      end
   end

   task automatic push_word(logic [15:0] w, string tag);
      for (int i = 15; i >= 0; i--) exp_q.push_back('{val: w[i], tag: tag});
   endtask

   task automatic wclk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_word(logic [15:0] w, bit with_start, string tag);
      if (with_start) begin
         conv_start = 1'b1; wclk(1); conv_start = 1'b0; wclk(2);
      end
      conv_data = w; conv_done = 1'b1; wclk(1); conv_done = 1'b0; wclk(1);
      exp_q.delete();
      push_word(w, tag);
   endtask

   // One serial cycle; idle_high selects the resting level of the clock
   task automatic cyc(bit idle_high, logic c);
      chain_in = c; wclk(1);
      if (idle_high) begin
         sclk = 1'b0; wclk(HALF); sclk = 1'b1; wclk(HALF);
      end else begin
         sclk = 1'b1; wclk(HALF); sclk = 1'b0; wclk(HALF);
      end
   endtask

   initial begin
      logic [15:0] up;
      wclk(3);
      chk("R9 ser_out", {31'd0, ser_out}, 32'd0);
      chk("R9 ser_oe",  {31'd0, ser_oe},  32'd0);
      chk("R9 busy",    {31'd0, busy},    32'd0);
      rst_n = 1'b1; wclk(2);

      // Test A: cascaded read-after-convert, idle-low clock
      conv_start = 1'b1; wclk(1); conv_start = 1'b0;
      chk("R4 busy after start", {31'd0, busy}, 32'd1);
      wclk(2);
      conv_data = 16'hA5C3; conv_done = 1'b1; wclk(1); conv_done = 1'b0;
      chk("R1 msb after load", {31'd0, ser_out}, 32'd1);
      chk("R4 busy after done", {31'd0, busy}, 32'd1);
      push_word(16'hA5C3, "R2");
      up = 16'h3C96;
      push_word(up, "R3");
      cs_n = 1'b0; rd_n = 1'b0; wclk(6);
      chk("R1 oe selected", {31'd0, ser_oe}, 32'd1);
      for (int k = 0; k < 15; k++) cyc(1'b0, up[15-k]);
      chk("R4 busy before last", {31'd0, busy}, 32'd1);
      cyc(1'b0, up[0]);
      chk("R4 busy after last", {31'd0, busy}, 32'd0);
      for (int k = 0; k < 16; k++) cyc(1'b0, 1'b0);
      chk("R3 chain drained", {26'd0, 6'(exp_q.size())}, 32'd0);

      // Test B: clock resting high
      cs_n = 1'b1; wclk(4);
      sclk = 1'b1; wclk(6);
      load_word(16'h5A0F, 1'b0, "R7");
      cs_n = 1'b0; wclk(6);
      for (int k = 0; k < 16; k++) cyc(1'b1, 1'b0);
      chk("R7 all read", {26'd0, 6'(exp_q.size())}, 32'd0);
      cs_n = 1'b1; wclk(4);
      sclk = 1'b0; wclk(6);

      // Test C: chip select released mid-read
      load_word(16'hC3E1, 1'b0, "R5");
      cs_n = 1'b0; wclk(6);
      for (int k = 0; k < 8; k++) cyc(1'b0, 1'b0);
      cs_n = 1'b1; wclk(6);
      chk("R1 oe deselected", {31'd0, ser_oe}, 32'd0);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1);
      chk("R5 position kept", {31'd0, ser_out}, {31'd0, exp_q[0].val});
      cs_n = 1'b0; wclk(6);
      for (int k = 0; k < 8; k++) cyc(1'b0, 1'b0);
      chk("R5 resumed all", {26'd0, 6'(exp_q.size())}, 32'd0);

      // Test D: read enable and mode select gating
      load_word(16'h9E37, 1'b0, "R6");
      for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0);
      rd_n = 1'b1; wclk(6);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0);
      chk("R6 rd_n high hold", {31'd0, ser_out}, {31'd0, exp_q[0].val});
      rd_n = 1'b0; mode_ext = 1'b0; wclk(6);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0);
      chk("R6 mode low hold", {31'd0, ser_out}, {31'd0, exp_q[0].val});
      mode_ext = 1'b1; wclk(6);
      for (int k = 0; k < 12; k++) cyc(1'b0, 1'b0);
      chk("R6 resumed all", {26'd0, 6'(exp_q.size())}, 32'd0);

      // Test E: new load in the middle of a readout
      load_word(16'h1234, 1'b1, "R8");
      for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0);
      load_word(16'hF00D, 1'b1, "R8");
      chk("R8 new msb", {31'd0, ser_out}, 32'd1);
      for (int k = 0; k < 15; k++) cyc(1'b0, 1'b0);
      chk("R8 busy after 15", {31'd0, busy}, 32'd1);
      cyc(1'b0, 1'b0);
      chk("R8 busy after 16", {31'd0, busy}, 32'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule